// File: doc/BRIEF.md
# Multicycle Processor Datapath

This block is the 32-bit datapath of a processor that runs each instruction over several clock cycles. It uses a single ALU and a single memory port. One memory holds both the instruction stream and the program data, so the address can come from either the program counter or the latched ALU result. The ALU does all of the arithmetic: the PC increment, the branch target, the effective address, and the register-to-register operations. Holding registers carry values between the steps of an instruction. These are the instruction register, the memory data register, the two operand latches and the result latch.

An external control state machine drives every select and enable input on each cycle. It reads back the opcode, the function field and the zero flag. The memory itself sits outside the block. The datapath presents an address, write data and a write enable, and it receives the read word back in the same cycle.

Top module: `mcdp_top`

## Requirements
- R1: With `rst` high at a clock edge, the PC, the instruction register and all holding registers clear to zero. Afterwards, with `i_addr_from_alu`=0, `mem_addr`, `o_opcode`, `o_funct` and `mem_wdata` read zero.
- R2: When `i_ir_wr`=1, the instruction register captures `mem_rdata` at the edge. `o_opcode` then shows its bits 31..26 and `o_funct` its bits 5..0. A fetch step is `i_alu_a_reg`=0 (PC), `i_alu_b_sel`=1, `i_alu_op`=0 (add), `i_pc_src`=0 and `i_pc_wr`=1, and it advances the PC by 4.
- R3: When `i_ir_wr`=0, the instruction register keeps its value, whatever `mem_rdata` carries.
- R4: The A latch loads register[IR 25..21] on every edge, and the B latch loads register[IR 20..16] on every edge. B drives `mem_wdata`. With `i_alu_a_reg`=1 the first ALU input is A; with 0 it is the PC.
- R5: The `i_alu_op` codes select: 0 add, 1 subtract, 2 and, 3 or, 4 xor, 5 nor, 6 signed set-less-than, 7 unsigned set-less-than. Both set-less-than codes give 1 or 0.
- R6: The `i_alu_b_sel` codes pick the second ALU input: 0 the B latch, 1 the constant 4, 2 IR 15..0 sign-extended, 3 that value shifted left by 2.
- R7: `i_addr_from_alu`=0 puts the PC on `mem_addr`, and 1 puts the ALU result latch there. `mem_we` follows `i_mem_wr`.
- R8: The register write index is IR 15..11 when `i_dst_rd`=1 and IR 20..16 when it is 0. The write data is the memory data latch when `i_wb_from_mdr`=1 and the ALU result latch otherwise. The memory data latch captures `mem_rdata` on every edge.
- R9: Register 0 always reads as zero, and writes to it have no effect.
- R10: The PC loads when `i_pc_wr`=1, or when `i_pc_wr_cond`=1 and the zero flag is set; otherwise it holds. `i_pc_src`=1 selects the ALU result latch as its next value.
- R11: `i_pc_src`=2 loads the PC with PC 31..28, then IR 25..0, then two zero bits.
- R12: `o_zero` is 1 exactly when the present combinational ALU result is zero, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| i_pc_wr | input | 1 | Unconditional PC write |
| i_pc_wr_cond | input | 1 | PC write when zero flag set |
| i_ir_wr | input | 1 | Instruction register load |
| i_mem_wr | input | 1 | Memory store request |
| i_addr_from_alu | input | 1 | Address select: 0 PC, 1 ALU result latch |
| i_rf_wr | input | 1 | Register file write enable |
| i_dst_rd | input | 1 | Destination index: 1 IR 15..11, 0 IR 20..16 |
| i_wb_from_mdr | input | 1 | Write data: 1 memory data latch, 0 ALU result latch |
| i_alu_a_reg | input | 1 | ALU first input: 1 A latch, 0 PC |
| i_alu_b_sel | input | 2 | ALU second input select |
| i_alu_op | input | 3 | ALU operation code |
| i_pc_src | input | 2 | PC source: 0 ALU, 1 ALU result latch, 2 jump |
| mem_rdata | input | 32 | Word read from memory |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Store data (B latch) |
| mem_we | output | 1 | Memory write enable |
| o_opcode | output | 6 | IR bits 31..26 |
| o_funct | output | 6 | IR bits 5..0 |
| o_zero | output | 1 | ALU result is zero |

## Verification
The bench builds the block with its default parameters: 32 data bits and 32 registers. At this size the real instruction field positions and the jump concatenation hold, so complete encoded programs run from a small word memory in the bench. The bench plays the part of the control machine and steps through the fetch, decode, execute, memory and write-back cycles. It reads results out through the B latch on `mem_wdata`, and the PC through `mem_addr`. This exposes the sign extension, the branch offset scaling, the protection of register 0 and both write-back sources.

// File: rtl/mcdp_pkg.sv
package mcdp_pkg;

    localparam int XLEN      = 32;
    localparam int IMM_W     = 16;
    localparam int JIDX_W    = 26;
    localparam int PC_HI_W   = 4;

    typedef enum logic [1:0] {
        BSRC_REG    = 2'd0,
        BSRC_FOUR   = 2'd1,
        BSRC_IMM    = 2'd2,
        BSRC_IMM_SH = 2'd3
    } bsrc_e;

    typedef enum logic [1:0] {
        PCSRC_ALU  = 2'd0,
        PCSRC_HOLD = 2'd1,
        PCSRC_JUMP = 2'd2,
        PCSRC_RSVD = 2'd3
    } pcsrc_e;

    typedef enum logic [2:0] {
        ALU_ADD  = 3'd0,
        ALU_SUB  = 3'd1,
        ALU_AND  = 3'd2,
        ALU_OR   = 3'd3,
        ALU_XOR  = 3'd4,
        ALU_NOR  = 3'd5,
        ALU_SLT  = 3'd6,
        ALU_SLTU = 3'd7
    } aluop_e;

    typedef struct packed {
        logic   pc_wr;
        logic   pc_wr_cond;
        logic   ir_wr;
        logic   mem_wr;
        logic   addr_alu;
        logic   rf_wr;
        logic   dst_rd;
        logic   wb_mdr;
        logic   a_reg;
        bsrc_e  b_sel;
        aluop_e op;
        pcsrc_e pc_src;
    } ctrl_t;

    function automatic logic [XLEN-1:0] sext_imm(input logic [IMM_W-1:0] imm);
        return {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm};
    endfunction

endpackage

// File: rtl/mcdp_regfile.sv
module mcdp_regfile #(
    parameter int W  = 32,
    parameter int N  = 32,
    localparam int AW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] ra1,
    input  logic [AW-1:0] ra2,
    output logic [W-1:0]  rd1,
    output logic [W-1:0]  rd2
);
    logic [W-1:0] regs [N];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) regs[i] <= '0;
        end else if (we && (waddr != '0)) begin
            regs[waddr] <= wdata;
        end
    end

    // index zero is hard-wired, whatever the array holds
    assign rd1 = (ra1 == '0) ? '0 : regs[ra1];
    assign rd2 = (ra2 == '0) ? '0 : regs[ra2];
endmodule

// File: rtl/mcdp_alu.sv
module mcdp_alu
    import mcdp_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  aluop_e       op,
    output logic [W-1:0] y,
    output logic         zero
);
    always_comb begin
        unique case (op)
            ALU_ADD:  y = a + b;
            ALU_SUB:  y = a - b;
            ALU_AND:  y = a & b;
            ALU_OR:   y = a | b;
            ALU_XOR:  y = a ^ b;
            ALU_NOR:  y = ~(a | b);
            ALU_SLT:  y = W'($signed(a) < $signed(b));
            ALU_SLTU: y = W'(a < b);
            default:  y = '0;
        endcase
    end

    assign zero = (y == '0);
endmodule

// File: rtl/mcdp_pc.sv
module mcdp_pc
    import mcdp_pkg::*;
#(
    parameter int W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic              wr_cond,
    input  logic              zero,
    input  pcsrc_e            src,
    input  logic [W-1:0]      alu_res,
    input  logic [W-1:0]      alu_hold,
    input  logic [JIDX_W-1:0] jidx,
    output logic [W-1:0]      pc
);
    logic [W-1:0] jump_tgt;
    logic [W-1:0] pc_next;
    logic         load;

    // region bits of the PC, then the word index, then two zero bits
    assign jump_tgt = W'({pc[W-1 -: PC_HI_W], jidx, 2'b00});

    always_comb begin
        unique case (src)
            PCSRC_HOLD: pc_next = alu_hold;
            PCSRC_JUMP: pc_next = jump_tgt;
            default:    pc_next = alu_res;
        endcase
    end

    assign load = wr | (wr_cond & zero);

    always_ff @(posedge clk) begin
        if (rst)       pc <= '0;
        else if (load) pc <= pc_next;
    end
endmodule

// File: rtl/mcdp_top.sv
module mcdp_top
    import mcdp_pkg::*;
#(
    parameter int DATA_W = XLEN,
    parameter int NREGS  = 32,
    localparam int RA_W  = $clog2(NREGS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              i_pc_wr,
    input  logic              i_pc_wr_cond,
    input  logic              i_ir_wr,
    input  logic              i_mem_wr,
    input  logic              i_addr_from_alu,
    input  logic              i_rf_wr,
    input  logic              i_dst_rd,
    input  logic              i_wb_from_mdr,
    input  logic              i_alu_a_reg,
    input  logic [1:0]        i_alu_b_sel,
    input  logic [2:0]        i_alu_op,
    input  logic [1:0]        i_pc_src,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_we,
    output logic [5:0]        o_opcode,
    output logic [5:0]        o_funct,
    output logic              o_zero
);
    ctrl_t ctl;

    assign ctl = '{
        pc_wr:      i_pc_wr,
        pc_wr_cond: i_pc_wr_cond,
        ir_wr:      i_ir_wr,
        mem_wr:     i_mem_wr,
        addr_alu:   i_addr_from_alu,
        rf_wr:      i_rf_wr,
        dst_rd:     i_dst_rd,
        wb_mdr:     i_wb_from_mdr,
        a_reg:      i_alu_a_reg,
        b_sel:      bsrc_e'(i_alu_b_sel),
        op:         aluop_e'(i_alu_op),
        pc_src:     pcsrc_e'(i_pc_src)
    };

    // holding registers
    logic [DATA_W-1:0] pc_q;
    logic [DATA_W-1:0] ir_q;
    logic [DATA_W-1:0] mdr_q;
    logic [DATA_W-1:0] a_q;
    logic [DATA_W-1:0] b_q;
    logic [DATA_W-1:0] aluout_q;

    // instruction fields
    logic [RA_W-1:0]   f_rs, f_rt, f_rd;
    logic [DATA_W-1:0] imm_x;

    assign f_rs  = ir_q[21 +: RA_W];
    assign f_rt  = ir_q[16 +: RA_W];
    assign f_rd  = ir_q[11 +: RA_W];
    assign imm_x = sext_imm(ir_q[IMM_W-1:0]);

    // register file
    logic [DATA_W-1:0] rf_rd1, rf_rd2, rf_wdata;
    logic [RA_W-1:0]   rf_waddr;

    assign rf_waddr = ctl.dst_rd ? f_rd : f_rt;
    assign rf_wdata = ctl.wb_mdr ? mdr_q : aluout_q;

    mcdp_regfile #(.W(DATA_W), .N(NREGS)) u_rf (
        .clk   (clk),
        .rst   (rst),
        .we    (ctl.rf_wr),
        .waddr (rf_waddr),
        .wdata (rf_wdata),
        .ra1   (f_rs),
        .ra2   (f_rt),
        .rd1   (rf_rd1),
        .rd2   (rf_rd2)
    );

    // ALU operand selection
    logic [DATA_W-1:0] alu_a, alu_b, alu_y;
    logic              alu_zero;

    assign alu_a = ctl.a_reg ? a_q : pc_q;

    always_comb begin
        unique case (ctl.b_sel)
            BSRC_REG:    alu_b = b_q;
            BSRC_FOUR:   alu_b = DATA_W'(4);
            BSRC_IMM:    alu_b = imm_x;
            BSRC_IMM_SH: alu_b = {imm_x[DATA_W-3:0], 2'b00};
            default:     alu_b = b_q;
        endcase
    end

    mcdp_alu #(.W(DATA_W)) u_alu (
        .a    (alu_a),
        .b    (alu_b),
        .op   (ctl.op),
        .y    (alu_y),
        .zero (alu_zero)
    );

    mcdp_pc #(.W(DATA_W)) u_pc (
        .clk      (clk),
        .rst      (rst),
        .wr       (ctl.pc_wr),
        .wr_cond  (ctl.pc_wr_cond),
        .zero     (alu_zero),
        .src      (ctl.pc_src),
        .alu_res  (alu_y),
        .alu_hold (aluout_q),
        .jidx     (ir_q[JIDX_W-1:0]),
        .pc       (pc_q)
    );

    // instruction register holds across the instruction
    always_ff @(posedge clk) begin
        if (rst)            ir_q <= '0;
        else if (ctl.ir_wr) ir_q <= mem_rdata;
    end

    // per-cycle latches
    always_ff @(posedge clk) begin
        if (rst) begin
            mdr_q    <= '0;
            a_q      <= '0;
            b_q      <= '0;
            aluout_q <= '0;
        end else begin
            mdr_q    <= mem_rdata;
            a_q      <= rf_rd1;
            b_q      <= rf_rd2;
            aluout_q <= alu_y;
        end
    end

    assign mem_addr  = ctl.addr_alu ? aluout_q : pc_q;
    assign mem_wdata = b_q;
    assign mem_we    = ctl.mem_wr;
    assign o_opcode  = ir_q[DATA_W-1 -: 6];
    assign o_funct   = ir_q[5:0];
    assign o_zero    = alu_zero;
endmodule

// File: rtl/mcdp_checker.sv
module mcdp_checker #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst,
    input logic         pc_wr,
    input logic         pc_wr_cond,
    input logic         ir_wr,
    input logic         a_reg,
    input logic [1:0]   b_sel,
    input logic [2:0]   op,
    input logic [1:0]   pc_src,
    input logic         zero,
    input logic [W-1:0] rdata,
    input logic [W-1:0] pc,
    input logic [W-1:0] ir,
    input logic [W-1:0] b
);
    assert_ir_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !ir_wr |=> $stable(ir));

    assert_ir_load_R2: assert property (@(posedge clk) disable iff (rst)
        ir_wr |=> ir == $past(rdata));

    assert_fetch_step_R2: assert property (@(posedge clk) disable iff (rst)
        (pc_wr && pc_src == 2'd0 && !a_reg && b_sel == 2'd1 && op == 3'd0)
        |=> pc == $past(pc) + W'(4));

    assert_pc_idle_R10: assert property (@(posedge clk) disable iff (rst)
        (!pc_wr && !(pc_wr_cond && zero)) |=> $stable(pc));

    assert_jump_aligned_R11: assert property (@(posedge clk) disable iff (rst)
        (pc_wr && pc_src == 2'd2) |=> pc[1:0] == 2'b00);

    assert_r0_reads_zero_R9: assert property (@(posedge clk) disable iff (rst)
        (ir[20:16] == 5'd0) |=> b == '0);
endmodule

bind mcdp_top mcdp_checker #(.W(DATA_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .pc_wr      (i_pc_wr),
    .pc_wr_cond (i_pc_wr_cond),
    .ir_wr      (i_ir_wr),
    .a_reg      (i_alu_a_reg),
    .b_sel      (i_alu_b_sel),
    .op         (i_alu_op),
    .pc_src     (i_pc_src),
    .zero       (o_zero),
    .rdata      (mem_rdata),
    .pc         (pc_q),
    .ir         (ir_q),
    .b          (b_q)
);

// File: tb/mcdp_top_test.sv
module mcdp_top_test;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pc_wr = 0, pc_wr_cond = 0, ir_wr = 0, mem_wr = 0, addr_alu = 0;
    logic rf_wr = 0, dst_rd = 0, wb_mdr = 0, a_reg = 0;
    logic [1:0]  b_sel = 0;
    logic [2:0]  op = 0;
    logic [1:0]  pc_src = 0;
    logic [31:0] mem_rdata;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_we;
    logic [5:0]  opcode, funct;
    logic        zero;

    logic [31:0] mem [64];
    logic [31:0] exp_pc;
    int total = 0;
    int bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign mem_rdata = mem[mem_addr[7:2]];

    mcdp_top uut (
        .clk(clk), .rst(rst),
        .i_pc_wr(pc_wr), .i_pc_wr_cond(pc_wr_cond), .i_ir_wr(ir_wr),
        .i_mem_wr(mem_wr), .i_addr_from_alu(addr_alu), .i_rf_wr(rf_wr),
        .i_dst_rd(dst_rd), .i_wb_from_mdr(wb_mdr), .i_alu_a_reg(a_reg),
        .i_alu_b_sel(b_sel), .i_alu_op(op), .i_pc_src(pc_src),
        .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_we(mem_we), .o_opcode(opcode), .o_funct(funct), .o_zero(zero)
    );

    // {op, a, b, expected}
    localparam logic [98:0] VEC [NVEC] = '{
        {3'd0, 32'h7FFF_FFFF, 32'h0000_0001, 32'h8000_0000},
        {3'd1, 32'h0000_0005, 32'h0000_0007, 32'hFFFF_FFFE},
        {3'd2, 32'hF0F0_00FF, 32'h0FF0_0F0F, 32'h00F0_000F},
        {3'd3, 32'hF0F0_00FF, 32'h0FF0_0F0F, 32'hFFF0_0FFF},
        {3'd4, 32'hAAAA_0000, 32'hA0A0_FFFF, 32'h0A0A_FFFF},
        {3'd5, 32'h0000_FFFF, 32'h00FF_0000, 32'hFF00_0000},
        {3'd6, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0001},
        {3'd7, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0000}
    };

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    function automatic logic [31:0] enc_r(input int rs, rt, rd, input logic [5:0] fn);
        return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
    endfunction

    function automatic logic [31:0] enc_i(input logic [5:0] opc, input int rs, rt, input logic [15:0] imm);
        return {opc, 5'(rs), 5'(rt), imm};
    endfunction

    task automatic cyc(input logic pw, pc_c, irw, mw, ad, rw, rd, wm, ar,
                       input logic [1:0] bs, input logic [2:0] o, input logic [1:0] ps);
        @(negedge clk);
        pc_wr = pw; pc_wr_cond = pc_c; ir_wr = irw; mem_wr = mw; addr_alu = ad;
        rf_wr = rw; dst_rd = rd; wb_mdr = wm; a_reg = ar; b_sel = bs; op = o; pc_src = ps;
        @(posedge clk);
        #1;
    endtask

    task automatic fetch(input logic [31:0] w);
        mem[exp_pc[7:2]] = w;
        cyc(1,0,1,0,0,0,0,0,0, 2'd1, 3'd0, 2'd0);
        exp_pc = exp_pc + 32'd4;
        check("R2 pc+4", mem_addr, exp_pc);
        check("R2 opcode/funct", {20'd0, opcode, funct}, {20'd0, w[31:26], w[5:0]});
    endtask

    task automatic decode();
        cyc(0,0,0,0,0,0,0,0,0, 2'd3, 3'd0, 2'd0);
    endtask

    task automatic do_addi(input int rt, rs, input logic [15:0] imm);
        fetch(enc_i(6'h08, rs, rt, imm));
        decode();
        cyc(0,0,0,0,0,0,0,0,1, 2'd2, 3'd0, 2'd0);
        cyc(0,0,0,0,0,1,0,0,1, 2'd2, 3'd0, 2'd0);
    endtask

    task automatic do_lw(input int rt, rs, input logic [15:0] imm);
        fetch(enc_i(6'h23, rs, rt, imm));
        decode();
        cyc(0,0,0,0,0,0,0,0,1, 2'd2, 3'd0, 2'd0);
        cyc(0,0,0,0,1,0,0,0,1, 2'd2, 3'd0, 2'd0);
        cyc(0,0,0,0,1,1,0,1,1, 2'd2, 3'd0, 2'd0);
    endtask

    task automatic do_rtype(input int rd, rs, rt, input logic [2:0] o);
        fetch(enc_r(rs, rt, rd, 6'h20));
        decode();
        cyc(0,0,0,0,0,0,0,0,1, 2'd0, o, 2'd0);
        cyc(0,0,0,0,0,1,1,0,1, 2'd0, o, 2'd0);
    endtask

    // brings register rt out on mem_wdata through the B latch
    task automatic probe(input int rt, input logic [31:0] exp, input string req);
        fetch(enc_i(6'h2B, 0, rt, 16'd0));
        decode();
        check(req, mem_wdata, exp);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        pc_wr = 0; pc_wr_cond = 0; ir_wr = 0; mem_wr = 0; addr_alu = 0;
        rf_wr = 0; dst_rd = 0; wb_mdr = 0; a_reg = 0; b_sel = 0; op = 0; pc_src = 0;
        @(posedge clk); @(posedge clk);
        #1;
        rst = 1'b0;
        exp_pc = 32'd0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = 32'd0;
        exp_pc = 32'd0;

        // ALU operation table: R4 operands, R5 ops, R8 both write-back paths
        for (int v = 0; v < NVEC; v++) begin
            do_reset();
            mem[48] = VEC[v][95:64];
            mem[49] = VEC[v][63:32];
            do_lw(1, 0, 16'd192);
            do_lw(2, 0, 16'd196);
            do_rtype(3, 1, 2, VEC[v][98:96]);
            probe(3, VEC[v][31:0], $sformatf("R5 op %0d", VEC[v][98:96]));
        end

        // R1: reset state
        do_reset();
        check("R1 mem_addr", mem_addr, 32'd0);
        check("R1 opcode", {26'd0, opcode}, 32'd0);
        check("R1 funct", {26'd0, funct}, 32'd0);
        check("R1 mem_wdata", mem_wdata, 32'd0);

        // R6 sign-extended immediate, R8 rt destination from ALU latch
        do_addi(4, 0, 16'hFFFD);
        probe(4, 32'hFFFF_FFFD, "R6 sext imm");

        // R9: write to register 0 dropped
        do_addi(0, 0, 16'd9);
        probe(0, 32'd0, "R9 r0 write ignored");

        // R3: IR holds while memory at the PC carries another word
        fetch(enc_i(6'h23, 0, 0, 16'd0));
        mem[exp_pc[7:2]] = 32'hFC00_003F;
        decode();
        check("R3 ir hold", {26'd0, opcode}, 32'h23);

        // R8 load path with negative offset (R6)
        mem[48] = 32'h1234_5678;
        do_addi(6, 0, 16'd196);
        do_lw(5, 6, 16'hFFFC);
        probe(5, 32'h1234_5678, "R8 load via mdr");

        // R7: store through ALU latch address
        mem[50] = 32'd0;
        fetch(enc_i(6'h2B, 0, 4, 16'd200));
        decode();
        cyc(0,0,0,0,0,0,0,0,1, 2'd2, 3'd0, 2'd0);
        @(negedge clk);
        mem_wr = 1; addr_alu = 1;
        #1;
        check("R7 addr from alu", mem_addr, 32'd200);
        check("R7 mem_we", {31'd0, mem_we}, 32'd1);
        mem[mem_addr[7:2]] = mem_wdata;
        @(posedge clk);
        #1;
        check("R7 stored word", mem[50], 32'hFFFF_FFFD);

        // R10 / R12: branch taken, target = pc+4 + (3<<2)
        fetch(enc_i(6'h04, 4, 4, 16'd3));
        decode();
        @(negedge clk);
        mem_wr = 0; addr_alu = 0; a_reg = 1; b_sel = 2'd0; op = 3'd1;
        pc_wr_cond = 1; pc_src = 2'd1;
        #1;
        check("R12 zero set", {31'd0, zero}, 32'd1);
        @(posedge clk);
        #1;
        exp_pc = exp_pc + 32'd12;
        check("R10 branch taken", mem_addr, exp_pc);

        // R10 / R12: branch not taken (r4 != r0)
        fetch(enc_i(6'h04, 4, 0, 16'd3));
        decode();
        @(negedge clk);
        a_reg = 1; b_sel = 2'd0; op = 3'd1; pc_wr_cond = 1; pc_src = 2'd1;
        #1;
        check("R12 zero clear", {31'd0, zero}, 32'd0);
        @(posedge clk);
        #1;
        check("R10 branch not taken", mem_addr, exp_pc);

        // R11: jump to word index 5
        fetch({6'h02, 26'd5});
        decode();
        cyc(1,0,0,0,0,0,0,0,0, 2'd0, 3'd0, 2'd2);
        exp_pc = {exp_pc[31:28], 26'd5, 2'b00};
        check("R11 jump target", mem_addr, exp_pc);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule